// File: doc/BRIEF.md
# Auto-Reloading Interval Countdown Timer

This block is a down-counter that measures an interval in time-base ticks. Software arms it by writing a start value, which is also kept as the reload value. Each cycle in which the time-base tick enable is high, the count drops by one. When the count steps from one to zero the timer has expired. It then asks the shared status register to set its flag bit. Depending on a control bit, it either restarts from the stored reload value or stays stopped at zero. Writing zero stops the timer without any event. The live count can be read at any time.

The shared timer control and status registers belong to a neighbouring block. They arrive here as full-width inputs, and this timer decodes only its own bit positions. The status flag is raised through a one-cycle bit-set vector. The neighbour merges that vector into the status register, and software clears the bit there. The interrupt request is a level formed from the status flag and the control enable bit. It therefore falls as soon as software clears the flag.

Top module: `interval_timer`

## Requirements
- R1: A write with `wr_en_i` high and a non-zero `wr_data_i` stores the value as the reload value and puts it on `count_o` one clock after the write edge.
- R2: A write of zero puts zero on `count_o` and stops the timer. Later ticks neither change the count nor raise `sts_set_o`.
- R3: Without a write, the count drops by one at each clock edge where `tick_i` is high and the count is non-zero. The count holds when `tick_i` is low, and it never goes below zero.
- R4: Expiry is a clock edge with `tick_i` high while the count is one. In the cycle after expiry, `sts_set_o` has bit 27 high (bit 31 is the most significant) for exactly one cycle. At all other times `sts_set_o` is zero.
- R5: `irq_o` equals status input bit 27 ANDed with control input bit 26, as a combinational level in the same cycle.
- R6: At expiry with no write, control input bit 22 selects the next count. When the bit is high the count becomes the stored reload value. When the bit is low the count becomes zero and the timer stops.
- R7: A write at the same edge as an expiry loads the written value in place of the auto-reload or stop. The expiry still raises bit 27 of `sts_set_o`.
- R8: Synchronous active-high reset clears the count, the reload value and `sts_set_o`. After reset, ticks leave the count at zero even with auto-reload enabled.
- R9: Auto-reload uses the most recently written value for every period that follows, until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick enable |
| wr_en_i | input | 1 | Write strobe for the timer register |
| wr_data_i | input | W | Start/reload value |
| ctl_i | input | REG_W | Shared timer control register (bits 26, 22 used) |
| sts_i | input | REG_W | Shared timer status register (bit 27 used) |
| count_o | output | W | Live remaining count |
| sts_set_o | output | REG_W | One-cycle bit-set request into the status register |
| irq_o | output | 1 | Interrupt request level |

## Verification
The count and the status bit-set pulse are each due one clock after the edge at which a write or tick is presented. The interrupt level follows its inputs within the same cycle. The bench drives each stimulus at a falling edge and samples just after the following rising edge. At that sample it compares both registered results against an arithmetic model updated for the same edge. The interrupt is sampled a short delay after its inputs change, with no clock edge in between.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W         = 32,
  parameter int REG_W     = 32,
  parameter int STS_BIT   = 27,
  parameter int IRQEN_BIT = 26,
  parameter int AUTO_BIT  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [REG_W-1:0] ctl_i,
  input  logic [REG_W-1:0] sts_i,
  output logic [W-1:0]     count_o,
  output logic [REG_W-1:0] sts_set_o,
  output logic             irq_o
);

  localparam logic [W-1:0]     ONE      = W'(1);
  localparam logic [REG_W-1:0] FLAG_SET = REG_W'(1) << STS_BIT;

  logic [W-1:0] cnt_q, reload_q;
  logic         fire_q;
  logic         expire;
  logic         unused_bits;

  assign expire      = tick_i && (cnt_q == ONE);
  assign count_o     = cnt_q;
  assign sts_set_o   = fire_q ? FLAG_SET : '0;
  assign irq_o       = sts_i[STS_BIT] & ctl_i[IRQEN_BIT];
  assign unused_bits = ^{ctl_i, sts_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= expire;
      if (wr_en_i) begin
        cnt_q    <= wr_data_i;
        reload_q <= wr_data_i;
      end else if (expire) begin
        cnt_q <= ctl_i[AUTO_BIT] ? reload_q : '0;
      end else if (tick_i && cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> count_o == $past(wr_data_i));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !tick_i) |=> $stable(count_o));

  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && count_o == '0) |=> count_o == '0);

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && tick_i && count_o > ONE) |=> count_o == $past(count_o) - ONE);

  a_r4_flag: assert property (@(posedge clk) disable iff (rst)
    (tick_i && count_o == ONE) |=> sts_set_o == FLAG_SET);

  a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && count_o == ONE) |=> sts_set_o == '0);

  a_r6_stop: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && tick_i && count_o == ONE && !ctl_i[AUTO_BIT]) |=> count_o == '0);

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl = '0;
  logic [31:0] sts = '0;
  logic [31:0] count;
  logic [31:0] sts_set;
  logic        irq;

  int          total = 0;
  int          fails = 0;
  logic [31:0] m_cnt = '0;
  logic [31:0] m_rl = '0;

  always #(CLK/2) clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctl_i(ctl), .sts_i(sts), .count_o(count), .sts_set_o(sts_set), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic we, input logic [31:0] d, input string req);
    logic fire;
    @(negedge clk);
    tick = t; wr_en = we; wr_data = d;
    fire = t && (m_cnt == 32'd1);
    if (we) begin
      m_cnt = d; m_rl = d;
    end else if (fire) begin
      m_cnt = ctl[22] ? m_rl : 32'd0;
    end else if (t && m_cnt != 0) begin
      m_cnt = m_cnt - 1;
    end
    @(posedge clk); #1;
    chk(count == m_cnt, req, "count", count, m_cnt);
    chk(sts_set == (fire ? 32'h0800_0000 : 32'd0), "R4", "sts_set", sts_set,
        fire ? 32'h0800_0000 : 32'd0);
  endtask

  initial begin
    #(CLK * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(count == 0, "R8", "reset count", count, 0);
    chk(sts_set == 0, "R8", "reset sts_set", sts_set, 0);
    @(negedge clk); rst = 1'b0;

    // R5: interrupt level over all flag/enable combinations
    for (int k = 0; k < 4; k++) begin
      sts = k[0] ? 32'h0800_0000 : 32'h0;
      ctl = k[1] ? 32'h0400_0000 : 32'h0;
      #1;
      chk(irq == (k[0] && k[1]), "R5", "irq", {31'd0, irq}, {31'd0, k[0] && k[1]});
    end
    sts = 32'hF7FF_FFFF; ctl = 32'hFFFF_FFFF & ~32'h0400_0000; #1;
    chk(irq == 1'b0, "R5", "irq other bits", {31'd0, irq}, 0);
    sts = 0; ctl = 0;

    // R1/R3/R4/R6: sweep start values, tick spacing and reload mode
    for (int a = 0; a < 2; a++) begin
      ctl = a[0] ? 32'h0040_0000 : 32'h0;
      for (int v = 1; v <= 8; v++) begin
        for (int g = 0; g < 3; g++) begin
          cyc(1'b0, 1'b1, v, "R1");
          for (int c = 0; c < 3 * v * (g + 1) + 4; c++)
            cyc((c % (g + 1)) == 0, 1'b0, 0, a[0] ? "R6" : "R3");
        end
      end
    end

    // R2: write zero stops
    ctl = 32'h0040_0000;
    cyc(1'b0, 1'b1, 5, "R1");
    cyc(1'b1, 1'b0, 0, "R3");
    cyc(1'b1, 1'b0, 0, "R3");
    cyc(1'b1, 1'b1, 0, "R2");
    for (int c = 0; c < 10; c++) cyc(1'b1, 1'b0, 0, "R2");

    // R7: write collides with expiry; R9: new reload used afterwards
    cyc(1'b0, 1'b1, 3, "R1");
    cyc(1'b1, 1'b0, 0, "R3");
    cyc(1'b1, 1'b0, 0, "R3");
    cyc(1'b1, 1'b1, 9, "R7");
    for (int c = 0; c < 30; c++) cyc(1'b1, 1'b0, 0, "R9");

    // R8: reset mid-run clears reload too
    cyc(1'b0, 1'b1, 6, "R1");
    cyc(1'b1, 1'b0, 0, "R3");
    @(negedge clk); rst = 1'b1; tick = 1'b1; wr_en = 1'b0;
    @(posedge clk); #1;
    chk(count == 0, "R8", "count after reset", count, 0);
    @(negedge clk); rst = 1'b0;
    m_cnt = 0; m_rl = 0;
    for (int c = 0; c < 8; c++) cyc(1'b1, 1'b0, 0, "R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule